// File: doc/BRIEF.md
# Conflict-Line Victim Buffer

This block is a four-entry, fully associative store that sits beside a direct-mapped data cache and keeps lines the cache has recently thrown out. The main cache itself is untouched, so an ordinary hit costs exactly what it did before. The controller consults the buffer only when the main cache misses. It presents the missing line address together with the line the main cache would displace.

If the buffer holds the requested line, it returns that line one cycle later. In the same operation it stores the displaced main-cache line in the entry that just emptied, so the two lines trade places without any memory traffic. If the buffer does not hold the line, it raises a memory refill request for that address. When the refill later evicts a main-cache line, the controller pushes that line in through the insert port.

Each entry holds the full line address, so any cache set can land in any entry. It also holds a line of data and a dirty flag that the block carries but never acts on. Free entries are used before any occupied one is overwritten. Once all entries are occupied, the entry written longest ago is the one replaced.

Top module: `victim_line_buffer`

## Requirements
- R1: After reset every entry is empty. `rsp_valid` and `mem_req_valid` are 0, and the first lookup of any address misses.
- R2: `rsp_valid` is 1 in exactly the cycle after each cycle in which `lk_valid` is 1, and 0 otherwise.
- R3: A lookup whose full line address matches a stored entry answers with `rsp_hit`=1 and the stored data and dirty flag, and `mem_req_valid` stays 0.
- R4: A lookup that matches no entry answers with `rsp_hit`=0 and, in that same cycle, `mem_req_valid`=1 and `mem_req_addr` equal to the looked-up address.
- R5: On a hit with `lk_vic_valid`=1, the hit entry is rewritten with the displaced line. Afterwards the displaced line hits with its own data and dirty flag, and the requested line misses.
- R6: On a hit with `lk_vic_valid`=0, the hit entry is emptied, so a repeat lookup of the same address misses.
- R7: An insert goes into the lowest-numbered empty entry whenever one exists, so no stored line is lost while an entry is free.
- R8: With all entries occupied, an insert overwrites the entry written least recently. A swap on a hit counts as a write of that entry.
- R9: An insert presented in the same cycle as a lookup is ignored. The inserted line then misses on a later lookup.
- R10: Matching uses every address bit, so two addresses that differ only in the most significant bit are distinct lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request after a main-cache miss |
| lk_addr | input | AW | Line address being looked up |
| lk_vic_valid | input | 1 | The main cache is displacing a valid line |
| lk_vic_addr | input | AW | Line address of the displaced line |
| lk_vic_data | input | DW | Data of the displaced line |
| lk_vic_dirty | input | 1 | Dirty flag of the displaced line |
| ins_valid | input | 1 | Insert the line evicted by a memory refill |
| ins_addr | input | AW | Line address to insert |
| ins_data | input | DW | Line data to insert |
| ins_dirty | input | 1 | Dirty flag to insert |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | The lookup found the line |
| rsp_data | output | DW | Line data on a hit |
| rsp_dirty | output | 1 | Dirty flag on a hit |
| mem_req_valid | output | 1 | Refill request to memory |
| mem_req_addr | output | AW | Line address of the refill |

## Verification
The hardest state to reach from the ports is a full buffer whose write order has been reshuffled by swaps and emptied entries. Every lookup changes that order, so checking it from outside also disturbs it. The bench keeps its own model of entries with write stamps and replays a long pseudo-random mix of inserts, swapping hits and plain hits over eight addresses. Half of those addresses differ from the other half only in the top bit. Each answer is compared with the model, so replacement order is judged by which lines survive.

// File: rtl/victim_line_buffer.sv
module victim_line_buffer #(
  parameter int N  = 4,
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_vic_valid,
  input  logic [AW-1:0] lk_vic_addr,
  input  logic [DW-1:0] lk_vic_data,
  input  logic          lk_vic_dirty,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic [DW-1:0] ins_data,
  input  logic          ins_dirty,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_dirty,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  vld, dty, match;
  logic [AW-1:0] tag  [N];
  logic [DW-1:0] dat  [N];
  logic [IW-1:0] rank [N];

  logic          hit, free_any;
  logic [IW-1:0] hit_idx, free_idx, old_idx, ins_idx, wr_idx;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag[g] == lk_addr);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    old_idx  = '0;
    free_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
      if (!vld[i]) begin
        free_idx = IW'(i);
        free_any = 1'b1;
      end
      if (rank[i] == '0) old_idx = IW'(i);
    end
  end

  assign hit     = |match;
  assign ins_idx = free_any ? free_idx : old_idx;

  wire do_ins  = ins_valid && !lk_valid;
  wire do_swap = lk_valid && hit && lk_vic_valid;
  wire do_kill = lk_valid && hit && !lk_vic_valid;
  wire do_wr   = do_ins || do_swap;

  assign wr_idx = do_swap ? hit_idx : ins_idx;

  wire [AW-1:0] wr_addr  = do_swap ? lk_vic_addr  : ins_addr;
  wire [DW-1:0] wr_data  = do_swap ? lk_vic_data  : ins_data;
  wire          wr_dirty = do_swap ? lk_vic_dirty : ins_dirty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      dty <= '0;
      for (int i = 0; i < N; i++) begin
        tag[i]  <= '0;
        dat[i]  <= '0;
        rank[i] <= IW'(i);
      end
    end else begin
      if (do_kill) vld[hit_idx] <= 1'b0;
      if (do_wr) begin
        vld[wr_idx] <= 1'b1;
        dty[wr_idx] <= wr_dirty;
        tag[wr_idx] <= wr_addr;
        dat[wr_idx] <= wr_data;
        for (int i = 0; i < N; i++) begin
          if (IW'(i) == wr_idx)          rank[i] <= IW'(N - 1);
          else if (rank[i] > rank[wr_idx]) rank[i] <= rank[i] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_data      <= '0;
      rsp_dirty     <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      rsp_valid     <= lk_valid;
      rsp_hit       <= lk_valid && hit;
      rsp_data      <= dat[hit_idx];
      rsp_dirty     <= dty[hit_idx];
      mem_req_valid <= lk_valid && !hit;
      mem_req_addr  <= lk_addr;
    end
  end
endmodule

module victim_line_buffer_chk #(
  parameter int N  = 4,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic [AW-1:0] lk_addr,
  input logic          ins_valid,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          mem_req_valid,
  input logic [AW-1:0] mem_req_addr,
  input logic [N-1:0]  vld
);
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> !mem_req_valid);
  p_miss_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (mem_req_valid && mem_req_addr == $past(lk_addr)));
  p_req_needs_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> rsp_valid);
  p_fill_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !lk_valid && !(&vld)) |=> ($countones(vld) == $countones($past(vld)) + 1));
endmodule

bind victim_line_buffer victim_line_buffer_chk #(.N(N), .AW(AW)) u_chk (
  .clk, .rst_n, .lk_valid, .lk_addr, .ins_valid, .rsp_valid, .rsp_hit,
  .mem_req_valid, .mem_req_addr, .vld
);

// File: tb/victim_line_buffer_tb.sv
module victim_line_buffer_tb;
  localparam int N = 4, AW = 10, DW = 32;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_vic_valid = 0, lk_vic_dirty = 0;
  logic [AW-1:0] lk_addr = '0, lk_vic_addr = '0;
  logic [DW-1:0] lk_vic_data = '0;
  logic ins_valid = 0, ins_dirty = 0;
  logic [AW-1:0] ins_addr = '0;
  logic [DW-1:0] ins_data = '0;
  logic rsp_valid, rsp_hit, rsp_dirty, mem_req_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_req_addr;

  victim_line_buffer #(.N(N), .AW(AW), .DW(DW)) u_dut (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  logic          m_v  [N];
  logic [AW-1:0] m_a  [N];
  logic [DW-1:0] m_d  [N];
  logic          m_y  [N];
  int            m_st [N];
  int            stamp = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int mfind(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return i;
    return -1;
  endfunction

  function automatic int mslot();
    int o = 0;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 1; i < N; i++) if (m_st[i] < m_st[o]) o = i;
    return o;
  endfunction

  function automatic logic [DW-1:0] mkdata(input logic [AW-1:0] a, input int s);
    return (DW'(a) * 32'h9E3779B1) ^ DW'(s * 7919);
  endfunction

  task automatic mwrite(input int e, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic y);
    m_v[e] = 1; m_a[e] = a; m_d[e] = d; m_y[e] = y; m_st[e] = stamp++;
  endtask

  task automatic do_insert(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic y);
    @(negedge clk);
    ins_valid = 1; ins_addr = a; ins_data = d; ins_dirty = y;
    @(negedge clk);
    ins_valid = 0;
    mwrite(mslot(), a, d, y);
  endtask

  task automatic do_lookup(input logic [AW-1:0] a, input logic vv, input logic [AW-1:0] va,
                           input logic [DW-1:0] vd, input logic vy, input string tagname);
    int e;
    e = mfind(a);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_vic_valid = vv;
    lk_vic_addr = va; lk_vic_data = vd; lk_vic_dirty = vy;
    @(negedge clk);
    lk_valid = 0; lk_vic_valid = 0;
    chk(rsp_valid === 1'b1, "R2 rsp_valid after lookup", 64'(rsp_valid), 64'd1);
    if (e >= 0) begin
      chk(rsp_hit === 1'b1, {"R3 hit ", tagname}, 64'(rsp_hit), 64'd1);
      chk(rsp_data === m_d[e], {"R3 hit data ", tagname}, 64'(rsp_data), 64'(m_d[e]));
      chk(rsp_dirty === m_y[e], "R3 hit dirty", 64'(rsp_dirty), 64'(m_y[e]));
      chk(mem_req_valid === 1'b0, "R3 no refill on hit", 64'(mem_req_valid), 64'd0);
      if (vv) mwrite(e, va, vd, vy);
      else m_v[e] = 0;
    end else begin
      chk(rsp_hit === 1'b0, {"R4 miss ", tagname}, 64'(rsp_hit), 64'd0);
      chk(mem_req_valid === 1'b1 && mem_req_addr === a, {"R4 refill ", tagname},
          {mem_req_valid, 53'd0, mem_req_addr}, {1'b1, 53'd0, a});
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 rsp_valid idle", 64'(rsp_valid), 64'd0);
  endtask

  function automatic logic [AW-1:0] pool(input int k);
    return AW'(k & 3) | (AW'((k >> 2) & 1) << (AW - 1)) | AW'(8);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_st[i] = 0; end
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(mem_req_valid === 1'b0, "R1 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    rst_n = 1;
    do_lookup(10'h005, 0, '0, '0, 0, "R1 empty after reset");

    for (int k = 0; k < 4; k++) do_insert(pool(k), mkdata(pool(k), k), k[0]);
    do_lookup(pool(1), 1, pool(1), mkdata(pool(1), 1), 1, "R7 all fills kept");
    do_insert(pool(4), mkdata(pool(4), 9), 0);
    do_lookup(pool(0), 0, '0, '0, 0, "R8 oldest replaced");
    do_lookup(pool(4), 1, pool(4), mkdata(pool(4), 9), 0, "R10 top-bit twin");
    do_insert(pool(5), mkdata(pool(5), 3), 1);
    do_lookup(pool(1), 0, '0, '0, 0, "R8 swap refreshed order");

    do_lookup(pool(3), 1, 10'h2AA, 32'hCAFE_0001, 1, "R5 swap hit");
    do_lookup(10'h2AA, 1, 10'h155, 32'h0000_BEEF, 0, "R5 victim present");
    do_lookup(pool(3), 0, '0, '0, 0, "R5 requested gone");
    do_lookup(10'h155, 0, '0, '0, 0, "R6 hit empties");
    do_lookup(10'h155, 0, '0, '0, 0, "R6 repeat misses");
    do_insert(10'h033, 32'h1234_5678, 0);
    do_lookup(pool(5), 1, pool(5), mkdata(pool(5), 3), 1, "R7 free slot used");

    @(negedge clk);
    lk_valid = 1; lk_addr = 10'h3F0; ins_valid = 1; ins_addr = 10'h0F0; ins_data = 32'h5555_AAAA;
    @(negedge clk);
    lk_valid = 0; ins_valid = 0;
    chk(rsp_hit === 1'b0 && mem_req_valid === 1'b1, "R9 concurrent lookup misses",
        {rsp_hit, mem_req_valid}, 64'd1);
    do_lookup(10'h0F0, 0, '0, '0, 0, "R9 insert ignored");

    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int k, vk;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      k = int'(lf[2:0]);
      if (lf[4:3] == 2'b00 && mfind(pool(k)) < 0) begin
        do_insert(pool(k), mkdata(pool(k), n), lf[5]);
      end else begin
        vk = -1;
        if (lf[6]) for (int j = 0; j < 8; j++)
          if (vk < 0 && j != k && mfind(pool((j + int'(lf[9:7])) & 7)) < 0) vk = (j + int'(lf[9:7])) & 7;
        if (vk == k) vk = -1;
        if (vk >= 0) do_lookup(pool(k), 1, pool(vk), mkdata(pool(vk), n + 1000), lf[10], "sweep R5 R8 R10");
        else do_lookup(pool(k), 0, '0, '0, 0, "sweep R6 R7");
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule